// File: doc/BRIEF.md
# Conversion Result Register Bank with Read Pointer

This block holds the results of a conversion sequence of one to four conversions and serves them to a host over a parallel read bus. Each end-of-conversion strobe writes its result word into the next slot of the bank, in sequence order. A read pointer selects the slot shown on the bus. A first-data flag tells the host when the pointer is on the first slot.

The host may read while the sequence is still running. The pointer never moves onto a slot that has no result yet: a read that would do so is held, and the pointer steps forward when that result arrives. After the sequence, each completed read moves the pointer forward. The read of the last result wraps the pointer back to the first slot, so the results can be read again and again in order. The sequence length is captured when the busy flag rises.

All inputs are sampled on the rising clock edge. A read completes when the clock edge sees the read strobe high after a cycle in which both read strobe and chip select were low. The bus and its enable are registered and follow the strobes by one cycle.

Top module: `conv_result_bank`

## Requirements
- R1: The k-th conversion-done strobe after a sequence start (k = 0, 1, ...) writes `result_i` into slot k. Strobes after the captured length has been reached are ignored.
- R2: The clock edge that takes the first result of a sequence puts the pointer on slot 0, and `first_o` is 1 from that edge on.
- R3: While `rst` is high, the pointer goes to slot 0, `first_o` becomes 1, `oe_o` becomes 0 and `data_o` becomes 0. `first_o` is 1 exactly when the pointer is on slot 0.
- R4: `oe_o` is 1 in the cycle after an edge that sampled `cs_n_i` and `rd_n_i` both low, and `data_o` then carries the slot under the pointer. Otherwise `oe_o` is 0 and `data_o` is all zeros.
- R5: Once all results of the sequence are stored, each completed read moves the pointer to the next slot, so successive reads return slots 0, 1, 2, ... in ascending order.
- R6: A completed read while the pointer is on the last slot of the sequence (slot length-1), and that slot holds a result, returns the pointer to slot 0. Reading then continues as a circular buffer.
- R7: A completed read whose next slot holds no result of the current sequence leaves the pointer where it is. The pointer moves onto that slot on the edge that stores its result.
- R8: `seq_len_i` (3 bits) is captured on the edge where `busy_i` is first seen high. A value of 0 counts as 1, and values above 4 count as 4.
- R9: A sequence start marks every slot empty and cancels any held read. A read completing on that same edge does not move the pointer.
- R10: A rising read strobe while `cs_n_i` was high in the cycle before does not move the pointer and does not raise `oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Sequence in progress; its rising edge starts a sequence |
| done_i | input | 1 | One-cycle end-of-conversion strobe |
| result_i | input | 14 | Conversion result that goes with `done_i` |
| seq_len_i | input | 3 | Number of conversions in the sequence |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| data_o | output | 14 | Read bus; zero when not enabled |
| oe_o | output | 1 | Bus enable |
| first_o | output | 1 | Pointer is on slot 0 |

## Verification
On every cycle, the assertions check how the bus enable follows the strobes, that an idle bus is zero, and that the first store raises the first-data flag. They also check that the pointer moves only on a store or a completed read, that it always lands on a slot holding a result, and that a read with chip select high leaves it alone. The actual values read back need the bench's scenarios: ascending order, the wrap, clamping of the length and dropping of extra strobes. The bench sweeps every length code. The hold-and-release behaviour during a sequence needs a scenario that interleaves reads with stores.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
  localparam int DEF_DATA_W   = 14;
  localparam int DEF_NUM_REGS = 4;

  // effective sequence length: 0 counts as 1, oversize saturates
  function automatic int clamp_len(input int v, input int n);
    if (v < 1) return 1;
    if (v > n) return n;
    return v;
  endfunction
endpackage

// File: rtl/crb_ptr_ctrl.sv
`timescale 1ns/1ps
module crb_ptr_ctrl #(
  parameter int NUM_REGS = crb_pkg::DEF_NUM_REGS,
  parameter int LEN_W    = $clog2(NUM_REGS + 1),
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                seq_start,
  input  logic                done,
  input  logic                rd_done,
  input  logic [LEN_W-1:0]    len_in,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [IDX_W-1:0]    ptr,
  output logic                first,
  output logic [NUM_REGS-1:0] valid
);
  logic [LEN_W-1:0]    last_q, last_e, cnt_q, cnt_e;
  logic [NUM_REGS-1:0] valid_q, valid_e;
  logic                pend_q, pend_e, pend_d;
  logic [IDX_W-1:0]    ptr_q, ptr_d, nxt;
  logic                first_q;

  always_comb begin
    last_e  = last_q;
    valid_e = valid_q;
    cnt_e   = cnt_q;
    pend_e  = pend_q;
    if (seq_start) begin
      last_e  = LEN_W'(crb_pkg::clamp_len(int'(len_in), NUM_REGS) - 1);
      valid_e = '0;
      cnt_e   = '0;
      pend_e  = 1'b0;
    end
    wr_en  = done && (cnt_e <= last_e);
    wr_idx = cnt_e[IDX_W-1:0];
    nxt    = (ptr_q == IDX_W'(NUM_REGS - 1)) ? '0 : ptr_q + 1'b1;

    ptr_d  = ptr_q;
    pend_d = pend_e;
    if (wr_en && cnt_e == '0) begin
      ptr_d  = '0;
      pend_d = 1'b0;
    end else if (rd_done && !seq_start) begin
      if (LEN_W'(ptr_q) == last_e && valid_e[ptr_q]) begin
        ptr_d  = '0;
        pend_d = 1'b0;
      end else if (valid_e[nxt] || (wr_en && wr_idx == nxt)) begin
        ptr_d  = nxt;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end else if (pend_e && wr_en && wr_idx == nxt) begin
      ptr_d  = nxt;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      cnt_q   <= '0;
      valid_q <= '0;
      pend_q  <= 1'b0;
      ptr_q   <= '0;
      first_q <= 1'b1;
    end else begin
      last_q  <= last_e;
      cnt_q   <= wr_en ? cnt_e + 1'b1 : cnt_e;
      valid_q <= valid_e | (wr_en ? (NUM_REGS'(1) << wr_idx) : '0);
      pend_q  <= pend_d;
      ptr_q   <= ptr_d;
      first_q <= (ptr_d == '0);
    end
  end

  assign ptr   = ptr_q;
  assign first = first_q;
  assign valid = valid_q;
endmodule

// File: rtl/crb_store.sv
`timescale 1ns/1ps
module crb_store #(
  parameter int DATA_W   = crb_pkg::DEF_DATA_W,
  parameter int NUM_REGS = crb_pkg::DEF_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/crb_bus.sv
`timescale 1ns/1ps
module crb_bus #(
  parameter int DATA_W = crb_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic              oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      data <= '0;
    end else begin
      oe   <= en;
      data <= en ? word : '0;
    end
  end
endmodule

// File: rtl/conv_result_bank.sv
`timescale 1ns/1ps
module conv_result_bank #(
  parameter int DATA_W   = crb_pkg::DEF_DATA_W,
  parameter int NUM_REGS = crb_pkg::DEF_NUM_REGS,
  parameter int LEN_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [LEN_W-1:0]  seq_len_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o,
  output logic              first_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic busy_q, rd_q, cs_q;
  logic seq_start, rd_done, wr_en;
  logic [IDX_W-1:0]    wr_idx, ptr;
  logic [NUM_REGS-1:0] valid;
  logic [DATA_W-1:0]   word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      busy_q <= busy_i;
      rd_q   <= rd_n_i;
      cs_q   <= cs_n_i;
    end
  end

  assign seq_start = busy_i && !busy_q;
  assign rd_done   = rd_n_i && !rd_q && !cs_q;

  crb_ptr_ctrl #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .seq_start(seq_start), .done(done_i),
    .rd_done(rd_done), .len_in(seq_len_i), .wr_en(wr_en), .wr_idx(wr_idx),
    .ptr(ptr), .first(first_o), .valid(valid)
  );

  crb_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(result_i),
    .rd_idx(ptr), .rd_data(word)
  );

  crb_bus #(.DATA_W(DATA_W)) bus_i (
    .clk(clk), .rst(rst), .en(!cs_n_i && !rd_n_i), .word(word),
    .data(data_o), .oe(oe_o)
  );
endmodule

// File: rtl/crb_chk.sv
`timescale 1ns/1ps
module crb_chk #(
  parameter int DATA_W   = crb_pkg::DEF_DATA_W,
  parameter int NUM_REGS = crb_pkg::DEF_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                busy_i,
  input logic                done_i,
  input logic                cs_n_i,
  input logic                rd_n_i,
  input logic [DATA_W-1:0]   data_o,
  input logic                oe_o,
  input logic                first_o,
  input logic [IDX_W-1:0]    ptr,
  input logic [NUM_REGS-1:0] valid
);
  logic rd_q, cs_q, busy_q, en_q, seen_q;
  logic start_c, rd_edge, rd_edge_nocs, first_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b1; cs_q <= 1'b1; busy_q <= 1'b0; en_q <= 1'b0; seen_q <= 1'b0;
    end else begin
      rd_q   <= rd_n_i;
      cs_q   <= cs_n_i;
      busy_q <= busy_i;
      en_q   <= !cs_n_i && !rd_n_i;
      if (start_c) seen_q <= done_i;
      else if (done_i) seen_q <= 1'b1;
    end
  end

  assign start_c      = busy_i && !busy_q;
  assign rd_edge      = rd_n_i && !rd_q && !cs_q;
  assign rd_edge_nocs = rd_n_i && !rd_q && cs_q;
  assign first_evt    = done_i && (start_c || !seen_q);

  assert_oe_follows_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    oe_o == en_q);
  assert_bus_zero_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> data_o == '0);
  assert_first_after_first_store_R2: assert property (@(posedge clk) disable iff (rst)
    first_evt |=> (first_o && valid[0]));
  assert_ptr_moves_on_event_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> $past(done_i || rd_edge));
  assert_ptr_lands_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> valid[ptr]);
  assert_cs_high_read_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_edge_nocs && !done_i) |=> $stable(ptr));
endmodule

bind conv_result_bank crb_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst(rst), .busy_i(busy_i), .done_i(done_i), .cs_n_i(cs_n_i),
  .rd_n_i(rd_n_i), .data_o(data_o), .oe_o(oe_o), .first_o(first_o),
  .ptr(ptr), .valid(valid)
);

// File: tb/conv_result_bank_tb_top.sv
`timescale 1ns/1ps
module conv_result_bank_tb_top;
  localparam int DW = 14;
  localparam int NR = 4;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b0, done = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] result = '0;
  logic [LW-1:0] seq_len = '0;
  logic [DW-1:0] data_o;
  logic oe_o, first_o;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  conv_result_bank #(.DATA_W(DW), .NUM_REGS(NR)) dut_i (
    .clk(clk), .rst(rst), .busy_i(busy), .done_i(done), .result_i(result),
    .seq_len_i(seq_len), .cs_n_i(cs_n), .rd_n_i(rd_n),
    .data_o(data_o), .oe_o(oe_o), .first_o(first_o)
  );

  function automatic logic [DW-1:0] val(input int s, input int k);
    return DW'((s * 4099 + k * 1237 + 16'h1555) & 16'h3fff);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic store(input logic [DW-1:0] d);
    @(negedge clk); done = 1'b1; result = d;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic start_seq(input int l);
    @(negedge clk); busy = 1'b1; seq_len = LW'(l);
    @(negedge clk);
  endtask

  // full read: returns bus value and enable seen while strobes low
  task automatic do_read(output logic [DW-1:0] d, output logic en);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); d = data_o; en = oe_o; rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic en;
    repeat (4) @(negedge clk);
    check("R3 first after reset", int'(first_o), 1);
    check("R3 oe after reset", int'(oe_o), 0);
    check("R3 data after reset", int'(data_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep every length code
    for (int lc = 0; lc < 8; lc++) begin
      int le;
      le = (lc < 1) ? 1 : ((lc > NR) ? NR : lc);
      start_seq(lc);
      for (int k = 0; k <= le; k++) begin
        store(val(lc, k));
        if (k == 0) check("R2 first after first store", int'(first_o), 1);
      end
      @(negedge clk); busy = 1'b0;
      for (int i = 0; i < 2 * le + 1; i++) begin
        do_read(d, en);
        check("R4 oe during read", int'(en), 1);
        check("R1 R5 R8 read value", int'(d), int'(val(lc, i % le)));
        check("R5 R6 R3 first after read", int'(first_o), ((i + 1) % le == 0) ? 1 : 0);
      end
      check("R4 idle oe", int'(oe_o), 0);
      check("R4 idle data", int'(data_o), 0);
      // read strobe with chip select high
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk);
      check("R10 oe with cs high", int'(oe_o), 0);
      rd_n = 1'b1;
      @(negedge clk);
      do_read(d, en);
      check("R10 pointer kept", int'(d), int'(val(lc, (2 * le + 1) % le)));
    end

    // reads interleaved with stores during a sequence of four
    start_seq(4);
    store(val(9, 0));
    check("R2 first flag", int'(first_o), 1);
    do_read(d, en);
    check("R7 read slot0", int'(d), int'(val(9, 0)));
    check("R7 R9 held on slot0", int'(first_o), 1);
    store(val(9, 1));
    check("R7 released by store", int'(first_o), 0);
    do_read(d, en);
    check("R7 read slot1", int'(d), int'(val(9, 1)));
    do_read(d, en);
    check("R7 still slot1", int'(d), int'(val(9, 1)));
    store(val(9, 2));
    do_read(d, en);
    check("R7 read slot2", int'(d), int'(val(9, 2)));
    store(val(9, 3));
    @(negedge clk); busy = 1'b0;
    do_read(d, en);
    check("R7 read slot3", int'(d), int'(val(9, 3)));
    check("R6 wrap after last", int'(first_o), 1);
    do_read(d, en);
    check("R6 circular slot0", int'(d), int'(val(9, 0)));
    check("R5 advanced", int'(first_o), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule